// File: doc/BRIEF.md
# Dual-Synthesizer Frequency-Hop Scheduler

This block sequences a frequency-hopping radio that has two phase-locked synthesizers working in alternation. At any moment one synthesizer carries the current channel. The other has already been given the next channel and has the whole dwell to settle. When a dwell expires, the roles swap in one cycle. The synthesizer that has just gone idle is then given the channel after the new one. Each synthesizer is therefore in service half of the time.

The hop order comes from a constant table of 43 slot numbers that is built into the logic and cannot be changed at run time. A resync pulse with a start index reloads both synthesizers from the table, resets the sequence position and restarts the dwell timer. Downstream logic serialises each channel word into its synthesizer when the matching load strobe is high, and drives the RF switch from the select line.

Top module: `hop_pingpong_ctrl`

## Requirements
- R1: After reset, and until the first resync, all outputs are zero and no hop tick occurs.
- R2: On the cycle after resync is sampled high, both load strobes are high, synth_sel_o is 0 (synthesizer A is active), seq_idx_o equals the start index, ch_a_o holds table[start] and ch_b_o holds table[start+1] (with wrap). A start index of 43 or more is treated as 0.
- R3: hop_tick_o is a one-cycle pulse. The first pulse comes DWELL_CYC cycles after the resync load cycle, and each later pulse comes DWELL_CYC cycles after the one before. DWELL_CYC = CLK_FREQ_HZ/1e6 * DWELL_US, which gives 10 ms by default.
- R4: synth_sel_o toggles on exactly the cycles in which hop_tick_o is high, and at no other time except a resync.
- R5: On each hop tick, seq_idx_o advances by one and wraps from 42 to 0.
- R6: In a hop-tick cycle exactly one load strobe is high. It belongs to the synthesizer that has just become inactive, and its channel word is table[seq_idx_o+1] (with wrap).
- R7: The active synthesizer is never loaded except by a resync. Its channel word always equals table[seq_idx_o].
- R8: The hop table entry i is (17*i + 5) mod 43. Over 43 consecutive hops, every slot 0..42 is active exactly once.
- R9: A resync during a dwell overrides the running schedule and restarts the timing from the new load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Start/resync request, sampled on the clock |
| start_idx_i | input | CH_W | Sequence position to start from on resync |
| synth_sel_o | output | 1 | Active synthesizer: 0 = A, 1 = B |
| ch_a_o | output | CH_W | Channel word for synthesizer A |
| ld_a_o | output | 1 | One-cycle load strobe for synthesizer A |
| ch_b_o | output | CH_W | Channel word for synthesizer B |
| ld_b_o | output | 1 | One-cycle load strobe for synthesizer B |
| hop_tick_o | output | 1 | One-cycle pulse at each dwell boundary |
| seq_idx_o | output | CH_W | Current position in the hop sequence |

## Verification
The bound checker examines every cycle. It confirms that each tick coincides with a select toggle, that ticks are spaced exactly one dwell apart, that the index steps and wraps, that a tick loads exactly one synthesizer (the idle one) with the following table entry, and that the active synthesizer is never retuned outside a resync. Some properties only the bench scenarios can show: the exact table contents and its permutation property across a full 43-hop cycle, the clamping of an out-of-range start index, the quiet state before the first resync, and the restart of timing when resync arrives in mid-dwell.

// File: rtl/hop_pkg.sv
package hop_pkg;

  typedef enum logic {
    SYN_A = 1'b0,
    SYN_B = 1'b1
  } synth_e;

  // Affine permutation over a prime-sized slot set: mult must be coprime to n.
  function automatic int unsigned hop_entry(input int unsigned i,
                                            input int unsigned n,
                                            input int unsigned mult,
                                            input int unsigned offs);
    return (mult * i + offs) % n;
  endfunction

endpackage

// File: rtl/hop_seq_rom.sv
module hop_seq_rom #(
  parameter int unsigned NUM_SLOTS = 43,
  parameter int unsigned HOP_MULT  = 17,
  parameter int unsigned HOP_OFFS  = 5,
  localparam int         CH_W      = $clog2(NUM_SLOTS)
) (
  input  logic [CH_W-1:0] addr0_i,
  input  logic [CH_W-1:0] addr1_i,
  output logic [CH_W-1:0] data0_o,
  output logic [CH_W-1:0] data1_o
);

  logic [CH_W-1:0] tbl [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tbl
    assign tbl[g] = CH_W'(hop_pkg::hop_entry(g, NUM_SLOTS, HOP_MULT, HOP_OFFS));
  end

  // Addresses are kept below NUM_SLOTS by the scheduler.
  assign data0_o = tbl[addr0_i];
  assign data1_o = tbl[addr1_i];

endmodule

// File: rtl/hop_dwell_timer.sv
module hop_dwell_timer #(
  parameter int unsigned DWELL_CYC = 16,
  localparam int         CNT_W     = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic boundary_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign boundary_o = run_i && (cnt_q == LAST);
  assign cnt_en     = restart_i || run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)       cnt_d = '0;
    else if (boundary_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hop_pingpong_sched.sv
module hop_pingpong_sched
  import hop_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 43,
  localparam int         CH_W      = $clog2(NUM_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resync_i,
  input  logic [CH_W-1:0] start_idx_i,
  input  logic            boundary_i,
  output logic            running_o,
  output logic [CH_W-1:0] rd_addr0_o,
  output logic [CH_W-1:0] rd_addr1_o,
  input  logic [CH_W-1:0] rd_data0_i,
  input  logic [CH_W-1:0] rd_data1_i,
  output logic            synth_sel_o,
  output logic [CH_W-1:0] ch_a_o,
  output logic            ld_a_o,
  output logic [CH_W-1:0] ch_b_o,
  output logic            ld_b_o,
  output logic            hop_tick_o,
  output logic [CH_W-1:0] seq_idx_o
);

  localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_SLOTS - 1);

  function automatic logic [CH_W-1:0] idx_inc(input logic [CH_W-1:0] x);
    return (x == LAST_IDX) ? '0 : x + 1'b1;
  endfunction

  logic            run_q, run_d;
  synth_e          sel_q, sel_d;
  logic [CH_W-1:0] idx_q, idx_d;
  logic [CH_W-1:0] cha_q, cha_d, chb_q, chb_d;
  logic            lda_q, lda_d, ldb_q, ldb_d;
  logic            tick_q, tick_d;
  logic [CH_W-1:0] start_c, nxt_idx, nxt2_idx;

  always_comb begin
    start_c  = (start_idx_i > LAST_IDX) ? '0 : start_idx_i;
    nxt_idx  = idx_inc(idx_q);
    nxt2_idx = idx_inc(nxt_idx);
  end

  // Port 0 serves only the resync load; port 1 serves the retune.
  assign rd_addr0_o = start_c;
  assign rd_addr1_o = resync_i ? idx_inc(start_c) : nxt2_idx;

  always_comb begin
    run_d  = run_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    cha_d  = cha_q;
    chb_d  = chb_q;
    lda_d  = 1'b0;
    ldb_d  = 1'b0;
    tick_d = 1'b0;
    if (resync_i) begin
      run_d = 1'b1;
      sel_d = SYN_A;
      idx_d = start_c;
      cha_d = rd_data0_i;
      chb_d = rd_data1_i;
      lda_d = 1'b1;
      ldb_d = 1'b1;
    end else if (boundary_i) begin
      tick_d = 1'b1;
      idx_d  = nxt_idx;
      if (sel_q == SYN_A) begin
        sel_d = SYN_B;
        cha_d = rd_data1_i;
        lda_d = 1'b1;
      end else begin
        sel_d = SYN_A;
        chb_d = rd_data1_i;
        ldb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= SYN_A;
      idx_q  <= '0;
      cha_q  <= '0;
      chb_q  <= '0;
      lda_q  <= 1'b0;
      ldb_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      cha_q  <= cha_d;
      chb_q  <= chb_d;
      lda_q  <= lda_d;
      ldb_q  <= ldb_d;
      tick_q <= tick_d;
    end
  end

  assign running_o   = run_q;
  assign synth_sel_o = sel_q;
  assign ch_a_o      = cha_q;
  assign ld_a_o      = lda_q;
  assign ch_b_o      = chb_q;
  assign ld_b_o      = ldb_q;
  assign hop_tick_o  = tick_q;
  assign seq_idx_o   = idx_q;

endmodule

// File: rtl/hop_pingpong_ctrl.sv
module hop_pingpong_ctrl #(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned DWELL_US    = 10_000,
  parameter int unsigned NUM_SLOTS   = 43,
  parameter int unsigned HOP_MULT    = 17,
  parameter int unsigned HOP_OFFS    = 5,
  localparam int         CH_W        = $clog2(NUM_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resync_i,
  input  logic [CH_W-1:0] start_idx_i,
  output logic            synth_sel_o,
  output logic [CH_W-1:0] ch_a_o,
  output logic            ld_a_o,
  output logic [CH_W-1:0] ch_b_o,
  output logic            ld_b_o,
  output logic            hop_tick_o,
  output logic [CH_W-1:0] seq_idx_o
);

  localparam int unsigned DWELL_CYC = (CLK_FREQ_HZ / 1_000_000) * DWELL_US;

  logic            boundary, running;
  logic [CH_W-1:0] rd_addr0, rd_addr1, rd_data0, rd_data1;

  hop_dwell_timer #(
    .DWELL_CYC (DWELL_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (resync_i),
    .run_i      (running),
    .boundary_o (boundary)
  );

  hop_seq_rom #(
    .NUM_SLOTS (NUM_SLOTS),
    .HOP_MULT  (HOP_MULT),
    .HOP_OFFS  (HOP_OFFS)
  ) u_rom (
    .addr0_i (rd_addr0),
    .addr1_i (rd_addr1),
    .data0_o (rd_data0),
    .data1_o (rd_data1)
  );

  hop_pingpong_sched #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .resync_i    (resync_i),
    .start_idx_i (start_idx_i),
    .boundary_i  (boundary),
    .running_o   (running),
    .rd_addr0_o  (rd_addr0),
    .rd_addr1_o  (rd_addr1),
    .rd_data0_i  (rd_data0),
    .rd_data1_i  (rd_data1),
    .synth_sel_o (synth_sel_o),
    .ch_a_o      (ch_a_o),
    .ld_a_o      (ld_a_o),
    .ch_b_o      (ch_b_o),
    .ld_b_o      (ld_b_o),
    .hop_tick_o  (hop_tick_o),
    .seq_idx_o   (seq_idx_o)
  );

endmodule

// File: rtl/hop_pingpong_chk.sv
module hop_pingpong_chk #(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned DWELL_US    = 10_000,
  parameter int unsigned NUM_SLOTS   = 43,
  parameter int unsigned HOP_MULT    = 17,
  parameter int unsigned HOP_OFFS    = 5,
  localparam int         CH_W        = $clog2(NUM_SLOTS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            resync_i,
  input logic            synth_sel_o,
  input logic [CH_W-1:0] ch_a_o,
  input logic            ld_a_o,
  input logic [CH_W-1:0] ch_b_o,
  input logic            ld_b_o,
  input logic            hop_tick_o,
  input logic [CH_W-1:0] seq_idx_o
);

  localparam int unsigned DWELL_CYC = (CLK_FREQ_HZ / 1_000_000) * DWELL_US;

  function automatic logic [CH_W-1:0] nxt(input logic [CH_W-1:0] x);
    return (int'(x) == NUM_SLOTS - 1) ? '0 : x + 1'b1;
  endfunction

  function automatic logic [CH_W-1:0] tbl(input logic [CH_W-1:0] x);
    return CH_W'(hop_pkg::hop_entry(int'(x), NUM_SLOTS, HOP_MULT, HOP_OFFS));
  endfunction

  // Cycles since the last tick or full reload, to check spacing without deep $past.
  logic [31:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             gap_q <= '0;
    else if (hop_tick_o || (ld_a_o && ld_b_o)) gap_q <= '0;
    else                                    gap_q <= gap_q + 1;
  end

  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    hop_tick_o |-> gap_q == DWELL_CYC - 1);

  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    hop_tick_o |=> !hop_tick_o);

  a_r4_tick_toggles_sel: assert property (@(posedge clk) disable iff (!rst_n)
    hop_tick_o |-> synth_sel_o != $past(synth_sel_o));

  a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!hop_tick_o && !(ld_a_o && ld_b_o)) |-> $stable(synth_sel_o));

  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    hop_tick_o |-> seq_idx_o == nxt($past(seq_idx_o)));

  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(seq_idx_o) < NUM_SLOTS);

  a_r6_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    hop_tick_o |-> $onehot({ld_a_o, ld_b_o}));

  a_r6_retune_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a_o && !ld_b_o) |-> (synth_sel_o && ch_a_o == tbl(nxt(seq_idx_o))));

  a_r6_retune_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_b_o && !ld_a_o) |-> (!synth_sel_o && ch_b_o == tbl(nxt(seq_idx_o))));

  a_r7_active_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_tick_o || (ld_a_o && ld_b_o)) |->
      ((synth_sel_o ? ch_b_o : ch_a_o) == tbl(seq_idx_o)));

  a_r2_reload_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a_o && ld_b_o) |-> (!synth_sel_o && !hop_tick_o));

  a_r9_reload_follows_resync: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> (ld_a_o && ld_b_o));

endmodule

bind hop_pingpong_ctrl hop_pingpong_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .DWELL_US    (DWELL_US),
  .NUM_SLOTS   (NUM_SLOTS),
  .HOP_MULT    (HOP_MULT),
  .HOP_OFFS    (HOP_OFFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .resync_i    (resync_i),
  .synth_sel_o (synth_sel_o),
  .ch_a_o      (ch_a_o),
  .ld_a_o      (ld_a_o),
  .ch_b_o      (ch_b_o),
  .ld_b_o      (ld_b_o),
  .hop_tick_o  (hop_tick_o),
  .seq_idx_o   (seq_idx_o)
);

// File: tb/hop_pingpong_ctrl_tb.sv
module hop_pingpong_ctrl_tb;

  localparam int D     = 16;   // 1 MHz x 16 us
  localparam int NS    = 43;
  localparam int CH_W  = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            resync;
  logic [CH_W-1:0] start_idx;
  logic            sel, ld_a, ld_b, tick;
  logic [CH_W-1:0] ch_a, ch_b, idx;

  int errors = 0;
  int checks = 0;
  int exp_idx;
  int exp_sel;

  always #5 clk = ~clk;

  hop_pingpong_ctrl #(
    .CLK_FREQ_HZ (1_000_000),
    .DWELL_US    (D)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .resync_i    (resync),
    .start_idx_i (start_idx),
    .synth_sel_o (sel),
    .ch_a_o      (ch_a),
    .ld_a_o      (ld_a),
    .ch_b_o      (ch_b),
    .ld_b_o      (ld_b),
    .hop_tick_o  (tick),
    .seq_idx_o   (idx)
  );

  // R8: table entry i = (17*i + 5) mod 43
  function automatic int tab(input int i);
    return (17 * i + 5) % NS;
  endfunction

  function automatic int wrap(input int i);
    return (i >= NS - 1) ? 0 : i + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: pulse resync and check the reload on the following cycle.
  task automatic do_resync(input int start);
    int s;
    s = (start >= NS) ? 0 : start;
    @(negedge clk);
    resync    = 1'b1;
    start_idx = CH_W'(start);
    @(negedge clk);
    resync = 1'b0;
    chk(ld_a && ld_b, "R2 both loads", {ld_a, ld_b}, 3);
    chk(sel == 1'b0 && int'(idx) == s, "R2 sel/idx", int'(idx), s);
    chk(int'(ch_a) == tab(s), "R2 ch_a", int'(ch_a), tab(s));
    chk(int'(ch_b) == tab(wrap(s)), "R2 ch_b", int'(ch_b), tab(wrap(s)));
    exp_idx = s;
    exp_sel = 0;
  endtask

  // R3..R7: walk n hops, checking quiet dwell and each boundary.
  task automatic run_hops(input int n, inout bit [NS-1:0] seen);
    for (int h = 0; h < n; h++) begin
      int quiet_bad;
      quiet_bad = 0;
      for (int c = 0; c < D - 1; c++) begin
        @(negedge clk);
        if (tick || ld_a || ld_b || int'(sel) != exp_sel) quiet_bad++;
      end
      chk(quiet_bad == 0, "R3/R7 quiet dwell", quiet_bad, 0);
      @(negedge clk);
      exp_idx = wrap(exp_idx);
      exp_sel = 1 - exp_sel;
      chk(tick, "R3 tick at boundary", tick, 1);
      chk(int'(sel) == exp_sel, "R4 sel toggle", sel, exp_sel);
      chk(int'(idx) == exp_idx, "R5 index step", int'(idx), exp_idx);
      if (exp_sel == 1) begin
        chk(ld_a && !ld_b && int'(ch_a) == tab(wrap(exp_idx)), "R6 retune A",
            int'(ch_a), tab(wrap(exp_idx)));
        chk(int'(ch_b) == tab(exp_idx), "R7 active B", int'(ch_b), tab(exp_idx));
        seen[ch_b] = 1'b1;
      end else begin
        chk(ld_b && !ld_a && int'(ch_b) == tab(wrap(exp_idx)), "R6 retune B",
            int'(ch_b), tab(wrap(exp_idx)));
        chk(int'(ch_a) == tab(exp_idx), "R7 active A", int'(ch_a), tab(exp_idx));
        seen[ch_a] = 1'b1;
      end
    end
  endtask

  // Scenario vectors: {start index, hop count}
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{0, 3}, '{7, 4}, '{41, 3}, '{42, 2}, '{20, 2}};

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100_000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    bit [NS-1:0] seen;
    int bad;
    rst_n     = 1'b0;
    resync    = 1'b0;
    start_idx = '0;
    seen      = '0;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk(!sel && !ld_a && !ld_b && !tick && ch_a == 0 && ch_b == 0 && idx == 0,
        "R1 reset state", {sel, ld_a, ld_b, tick}, 0);
    rst_n = 1'b1;
    bad = 0;
    for (int c = 0; c < 3 * D; c++) begin
      @(negedge clk);
      if (tick || ld_a || ld_b || sel || idx != 0) bad++;
    end
    chk(bad == 0, "R1 idle before resync", bad, 0);

    for (int v = 0; v < NV; v++) begin
      do_resync(VEC[v][0]);
      run_hops(VEC[v][1], seen);
    end

    // R5 wrap 42 -> 0 across a longer run
    do_resync(40);
    run_hops(5, seen);

    // R2 out-of-range start index clamps to 0
    do_resync(50);
    run_hops(1, seen);

    // R9 resync in mid-dwell restarts timing
    do_resync(3);
    repeat (5) @(negedge clk);
    do_resync(10);
    run_hops(2, seen);

    // R8 one full cycle visits every slot once
    do_resync(0);
    seen = '0;
    seen[tab(0)] = 1'b1;
    run_hops(NS - 1, seen);
    chk(seen == {NS{1'b1}}, "R8 permutation", $countones(seen), NS);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule